// File: doc/BRIEF.md
# Port-I/O Window Bridge

This block lets a processor reach a 16-bit-addressed port-I/O bus through a fixed 64 KB slice of its physical address space. A request on the processor side carries an address, an access size, a write flag and write data, and is offered with a valid/ready handshake. When the address falls inside the window, the bridge claims the request. It forwards the low 16 address bits, the access width and the data to the port bus under a select strobe. It then waits for the port side to acknowledge before it completes the request.

The processor side may be big-endian while the port bus is little-endian. When the `BIG_ENDIAN` parameter is set, the bridge reverses the byte order of halfword and word data in both directions. Byte data is never reordered. Requests outside the window, and requests with the reserved size code, are left unclaimed so that another target on the processor bus can answer them. Only one access is in flight at a time.

Top module: `io_window_bridge`

## Requirements
- R1: After reset, `io_sel` and `req_ready` are low and stay low until a request is claimed.
- R2: A request is claimed only when address bits [31:16] equal 0x1400. For any other address, `io_sel` and `req_ready` stay low for as long as the request is held.
- R3: The port address `io_addr` equals bits [15:0] of the claimed request address.
- R4: Size codes are 2'b00 byte, 2'b01 halfword and 2'b10 word, and `io_width` carries the same code. A request with size 2'b11 is not claimed: `io_sel` and `req_ready` stay low.
- R5: A byte access puts `req_wdata[7:0]` unchanged on `io_wdata[7:0]` with bits [31:8] zero. A byte read returns `io_rdata[7:0]` in `rsp_rdata[7:0]` with bits [31:8] zero.
- R6: With `BIG_ENDIAN` set, a halfword write drives `io_wdata` = {16'h0, wdata[7:0], wdata[15:8]}. A halfword read returns {16'h0, rdata[7:0], rdata[15:8]}.
- R7: With `BIG_ENDIAN` set, a word access reverses all four bytes in both directions: byte 0 goes to byte 3, byte 1 to byte 2, byte 2 to byte 1 and byte 3 to byte 0.
- R8: `io_sel` rises on the clock edge after a request is claimed. It holds `io_addr`, `io_width`, `io_write` and `io_wdata` steady until `io_ack` is sampled high, then falls.
- R9: `req_ready` pulses high for exactly one cycle, on the edge after `io_ack` is sampled with `io_sel`, and `rsp_rdata` holds the read result in that cycle.
- R10: Only one access is outstanding. `io_sel` is never high while `req_ready` is high, and a new request is not accepted in the cycle `req_ready` is high.
- R11: `io_write` equals the `req_write` value of the claimed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor request offered |
| req_ready | output | 1 | One-cycle completion of a claimed request |
| req_addr | input | 32 | Processor physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_rdata | output | 32 | Read data, valid while req_ready is high |
| io_sel | output | 1 | Port-bus access strobe |
| io_write | output | 1 | Port-bus direction |
| io_width | output | 2 | Port-bus access width, same coding as req_size |
| io_addr | output | 16 | Port address |
| io_wdata | output | 32 | Port write data, little-endian lanes |
| io_rdata | input | 32 | Port read data |
| io_ack | input | 1 | Port-bus acknowledge |

## Verification
The data patterns use a distinct value in every byte lane, for example 0x11223344 and 0xA1B2C3D4. A lane that is swapped wrongly, left unswapped or not zeroed therefore shows up as a wrong value rather than an accidental match. Each size is run as both a read and a write, and the device acknowledges after varying delays. Those delays separate a bridge that waits for the acknowledge from one that finishes early. Addresses just below, just above and at both ends of the window tell a correct window decode from an off-by-one. A reserved size inside the window shows that the size check is separate from the address decode.

// File: rtl/io_window_bridge.sv
module io_window_bridge #(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          WIN_BITS   = 16,
  parameter int          PORT_W     = 16,
  parameter logic [31:0] WIN_BASE   = 32'h1400_0000,
  parameter bit          BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              io_sel,
  output logic              io_write,
  output logic [1:0]        io_width,
  output logic [PORT_W-1:0] io_addr,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic              io_ack
);

  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_BITS];

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} state_t;
  state_t st;

  logic [PORT_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              hit;

  function automatic logic [DATA_W-1:0] lane_fix(input logic [1:0] sz, input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r;
    r = '0;
    case (sz)
      2'b00: r[7:0] = d[7:0];
      2'b01: r[15:0] = BIG_ENDIAN ? {d[7:0], d[15:8]} : d[15:0];
      default: r[31:0] = BIG_ENDIAN ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d[31:0];
    endcase
    return r;
  endfunction

  assign hit = (req_addr[ADDR_W-1:WIN_BITS] == WIN_TAG) && (req_size != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      size_q  <= 2'b00;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid && hit) begin
          addr_q  <= req_addr[PORT_W-1:0];
          size_q  <= req_size;
          wr_q    <= req_write;
          wdata_q <= lane_fix(req_size, req_wdata);
          st      <= S_WAIT;
        end
        S_WAIT: if (io_ack) begin
          rdata_q <= lane_fix(size_q, io_rdata);
          st      <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign io_sel    = (st == S_WAIT);
  assign req_ready = (st == S_DONE);
  assign io_addr   = addr_q;
  assign io_width  = size_q;
  assign io_write  = wr_q;
  assign io_wdata  = wdata_q;
  assign rsp_rdata = rdata_q;

  AST_SEL_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_sel) |-> ($past(req_addr[ADDR_W-1:WIN_BITS]) == WIN_TAG) && ($past(req_size) != 2'b11)); // R2
  AST_PORT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_sel) |-> io_addr == $past(req_addr[PORT_W-1:0])); // R3
  AST_WIDTH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_sel) |-> io_width == $past(req_size)); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel && !io_ack |=> io_sel && $stable(io_addr) && $stable(io_wdata) && $stable(io_width) && $stable(io_write)); // R8
  AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel && io_ack |=> req_ready && !io_sel); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready && !io_sel); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_sel && req_ready)); // R10
  AST_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_sel) |-> io_write == $past(req_write)); // R11

endmodule

// File: tb/io_window_bridge_tb_top.sv
module io_window_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, io_ack = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, io_rdata = '0;
  logic [1:0] req_size = 2'b00;
  logic req_ready, io_sel, io_write;
  logic [1:0] io_width;
  logic [15:0] io_addr;
  logic [31:0] io_wdata, rsp_rdata;

  int pass_cnt = 0, fail_cnt = 0, cyc = 0;
  int ack_delay = 1;
  logic [31:0] dev_data = '0;

  typedef struct { logic [15:0] addr; logic [1:0] width; logic wr; logic [31:0] wdata; string tag; } io_item_t;
  io_item_t exp_q[$];
  io_item_t cur;
  logic prev_sel = 1'b0;

  always #10 clk = ~clk;

  io_window_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .io_sel(io_sel),
    .io_write(io_write), .io_width(io_width), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    if (ok) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] be_lanes(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'b00:   return {24'h0, d[7:0]};
      2'b01:   return {16'h0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  // device model: acknowledges after ack_delay cycles
  always @(negedge clk) begin
    if (io_ack) io_ack <= 1'b0;
    else if (io_sel) begin
      if (ack_delay == 0) begin io_ack <= 1'b1; io_rdata <= dev_data; end
      else ack_delay <= ack_delay - 1;
    end
  end

  // monitor: pop expected port-bus item on each new select, check hold while selected
  always @(negedge clk) begin
    if (rst_n) begin
      if (io_sel && !prev_sel) begin
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected select", 32'(io_addr), 32'h0);
        else begin
          cur = exp_q.pop_front();
          check(io_addr == cur.addr, {cur.tag, " R3 port address"}, 32'(io_addr), 32'(cur.addr));
          check(io_width == cur.width, {cur.tag, " R4 width"}, 32'(io_width), 32'(cur.width));
          check(io_write == cur.wr, {cur.tag, " R11 direction"}, 32'(io_write), 32'(cur.wr));
          if (cur.wr) check(io_wdata == cur.wdata, {cur.tag, " R5/R6/R7 write lanes"}, io_wdata, cur.wdata);
        end
      end else if (io_sel && prev_sel) begin
        check(io_addr == cur.addr && io_wdata == (cur.wr ? cur.wdata : io_wdata),
              "R8 hold while selected", 32'(io_addr), 32'(cur.addr));
      end
      if (io_sel && req_ready) check(1'b0, "R10 select with ready", 32'(io_sel), 32'h0);
      prev_sel <= io_sel;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fail_cnt++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input logic [31:0] dd, input int dly, input string tag);
    io_item_t it;
    int n;
    it.addr = a[15:0]; it.width = sz; it.wr = wr; it.wdata = be_lanes(sz, wd); it.tag = tag;
    exp_q.push_back(it);
    dev_data = dd; ack_delay = dly;
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    n = 0;
    @(negedge clk);
    while (!req_ready && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(req_ready, {tag, " R9 completion"}, 32'(req_ready), 32'h1);
    check(n == dly + 1, {tag, " R8 waits for ack"}, n, dly + 1);
    if (!wr) check(rsp_rdata == be_lanes(sz, dd), {tag, " R5/R6/R7 read lanes"}, rsp_rdata, be_lanes(sz, dd));
    req_valid = 1'b0;
    @(negedge clk);
    check(!req_ready, {tag, " R9 single-cycle ready"}, 32'(req_ready), 32'h0);
  endtask

  task automatic unclaimed(input logic [31:0] a, input logic [1:0] sz, input string tag);
    bit seen = 1'b0;
    req_addr = a; req_size = sz; req_write = 1'b1; req_wdata = 32'hDEADBEEF; req_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (io_sel || req_ready) seen = 1'b1;
    end
    check(!seen, tag, 32'(seen), 32'h0);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!io_sel && !req_ready, "R1 reset outputs", {30'h0, io_sel, req_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!io_sel && !req_ready, "R1 idle after reset", {30'h0, io_sel, req_ready}, 32'h0);

    access(32'h1400_0040, 2'b00, 1'b1, 32'hA1B2C3D4, 32'h0, 0, "R5 byte write");
    access(32'h1400_03F8, 2'b00, 1'b0, 32'h0, 32'h5566_7788, 2, "R5 byte read");
    access(32'h1400_1234, 2'b01, 1'b1, 32'h1122_3344, 32'h0, 1, "R6 half write");
    access(32'h1400_0060, 2'b01, 1'b0, 32'h0, 32'hCAFE_BABE, 3, "R6 half read");
    access(32'h1400_0300, 2'b10, 1'b1, 32'h1122_3344, 32'h0, 0, "R7 word write");
    access(32'h1400_0304, 2'b10, 1'b0, 32'h0, 32'hA1B2_C3D4, 5, "R7 word read");
    access(32'h1400_0000, 2'b10, 1'b0, 32'h0, 32'h0102_0304, 1, "R2 window low edge");
    access(32'h1400_FFFF, 2'b00, 1'b1, 32'h0000_00E7, 32'h0, 2, "R2 R3 window high edge");

    unclaimed(32'h13FF_FFFF, 2'b00, "R2 below window");
    unclaimed(32'h1401_0000, 2'b10, "R2 above window");
    unclaimed(32'h9400_0040, 2'b01, "R2 upper bits differ");
    unclaimed(32'h1400_0010, 2'b11, "R4 reserved size");

    access(32'h1400_7777, 2'b01, 1'b1, 32'hFFFF_0F1E, 32'h0, 4, "R10 after unclaimed");
    check(exp_q.size() == 0, "R10 all items consumed", exp_q.size(), 32'h0);

    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end
endmodule